// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers eight external request pins and turns them into a single prioritised request for a processor core. Each pin passes through a two-flop synchroniser. A per-line sense setting then selects what counts as an event: a low level, a rising edge, a falling edge or, on the upper four lines, either edge. Edge events are latched in a flag register. A low level is not latched; it requests only while the synchronised pin stays low.

A line is eligible when it is pending (its flag is set or its level is active) and its mask bit is set. When the global enable is also set, the lowest-numbered eligible line is presented as `irq_req` together with its index on `irq_vec`. The core answers with `irq_ack`, which clears the flag of the line it was given and drops the global enable. It later pulses `irq_ret` to raise the enable again. Software can also set or clear the global enable directly, and can clear any flag by writing 1 to its bit.

Flags follow the pins whatever their mask. Nothing in the block depends on whether a pad is driven as an output, so events are seen in either case.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all flags, all mask bits and the global enable are 0, every line's sense setting is 00, the synchroniser stages hold 1, and `irq_req` is 0.
- R2: With sense 11 (bits [2i+1:2i] of `mode_wdata` for line i), a 0-to-1 change on a pin sets that line's flag. The flag is visible after the third rising clock edge that samples the new pin level.
- R3: With sense 10, a 1-to-0 change sets the flag, and a 0-to-1 change does not.
- R4: With sense 01, lines 4 to 7 set their flag on both edges, while lines 0 to 3 treat the setting as disabled and never set a flag or request.
- R5: With sense 00, a line requests for as long as its synchronised pin is low, its flag is never set by the pin, and the request ends once the synchronised pin is high again.
- R6: A flag is set by its trigger whether or not the line is masked.
- R7: `irq_req` is 1 only when some pending line has its mask bit set and the global enable is 1.
- R8: When several eligible lines are pending, `irq_vec` gives the lowest line number.
- R9: `irq_ack` while `irq_req` is 1 clears the flag of line `irq_vec` and clears the global enable at that clock edge. `irq_ack` while `irq_req` is 0 has no effect.
- R10: `flag_clr` clears the flags whose bits are 1 in `flag_clr_data` and leaves the others alone. A trigger on the same line in the same cycle wins over the clear.
- R11: `gie_set` or `irq_ret` sets the global enable. `gie_clr`, or an accepted acknowledge, clears it and wins when both happen in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous external request pins |
| mode_wr | input | 1 | Load all sense settings |
| mode_wdata | input | 16 | Two sense bits per line, line i at [2i+1:2i] |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask, 1 enables the line |
| flag_clr | input | 1 | Write-1-to-clear strobe for the flags |
| flag_clr_data | input | 8 | Flags to clear |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from service, re-enables |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 3 | Index of the presented line |
| flag_q | output | 8 | Current flag register |
| gie_q | output | 1 | Current global enable |

## Verification
The assertions assume that every control strobe is a clean synchronous input that is 0 or 1 on each edge. The pins alone are treated as asynchronous. They also assume that `irq_ack` is only meaningful while `irq_req` is high. The stimulus therefore changes pins and strobes only on the falling clock edge. It holds the pins high through reset so that no edge appears out of reset. Pin changes are kept rare in the random phase, so that rise, fall and level events are each seen in isolation as well as overlapping.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic low;
    } line_view_t;

    // Edge event for one line under its sense setting.
    function automatic logic edge_hit(input sense_e m, input line_view_t v,
                                      input logic any_ok);
        case (m)
            SENSE_RISE: return v.rise;
            SENSE_FALL: return v.fall;
            SENSE_ANY:  return any_ok & (v.rise | v.fall);
            default:    return 1'b0;
        endcase
    endfunction

    // Level request for one line under its sense setting.
    function automatic logic level_hit(input sense_e m, input line_view_t v);
        return (m == SENSE_LOW) & v.low;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] synced,
    output logic [N-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [N-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) chain[s] <= '1;
        end else begin
            chain[0] <= pin;
            for (int s = 1; s < DEPTH; s++) chain[s] <= chain[s-1];
        end
    end

    assign synced = chain[STAGES-1];
    assign prev   = chain[STAGES];
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int N        = 8,
    parameter int ANY_FROM = 4
) (
    input  logic [N-1:0]   synced,
    input  logic [N-1:0]   prev,
    input  logic [2*N-1:0] mode,
    output logic [N-1:0]   trig,
    output logic [N-1:0]   lvl
);
    for (genvar i = 0; i < N; i++) begin : g_line
        localparam logic ANY_OK = (i >= ANY_FROM);
        line_view_t view;
        sense_e     sel;

        assign view.rise = synced[i] & ~prev[i];
        assign view.fall = ~synced[i] & prev[i];
        assign view.low  = ~synced[i];
        assign sel       = sense_e'(mode[2*i +: 2]);

        assign trig[i] = edge_hit(sel, view, ANY_OK);
        assign lvl[i]  = level_hit(sel, view);
    end
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && !found) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
        any   = |elig;
        grant = elig & (~elig + N'(1));
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int ANY_FROM    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int VW          = $clog2(N_LINES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_LINES-1:0]     pin_in,
    input  logic                   mode_wr,
    input  logic [2*N_LINES-1:0]   mode_wdata,
    input  logic                   mask_wr,
    input  logic [N_LINES-1:0]     mask_wdata,
    input  logic                   flag_clr,
    input  logic [N_LINES-1:0]     flag_clr_data,
    input  logic                   gie_set,
    input  logic                   gie_clr,
    input  logic                   irq_ack,
    input  logic                   irq_ret,
    output logic                   irq_req,
    output logic [VW-1:0]          irq_vec,
    output logic [N_LINES-1:0]     flag_q,
    output logic                   gie_q
);
    logic [2*N_LINES-1:0] mode_r;
    logic [N_LINES-1:0]   mask_r;
    logic [N_LINES-1:0]   flag_r;
    logic                 gie_r;

    logic [N_LINES-1:0]   synced, prev;
    logic [N_LINES-1:0]   trig, lvl_act;
    logic [N_LINES-1:0]   elig, grant;
    logic [N_LINES-1:0]   clr_mask, ack_mask;
    logic                 any_elig, ack_hit, gie_nx;
    logic [VW-1:0]        win_idx;

    ext_irq_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin    (pin_in),
        .synced (synced),
        .prev   (prev)
    );

    ext_irq_sense #(.N(N_LINES), .ANY_FROM(ANY_FROM)) u_sense (
        .synced (synced),
        .prev   (prev),
        .mode   (mode_r),
        .trig   (trig),
        .lvl    (lvl_act)
    );

    assign elig = (flag_r | lvl_act) & mask_r & {N_LINES{gie_r}};

    ext_irq_prio #(.N(N_LINES), .IW(VW)) u_prio (
        .elig  (elig),
        .any   (any_elig),
        .idx   (win_idx),
        .grant (grant)
    );

    assign ack_hit  = irq_ack & any_elig;
    assign clr_mask = flag_clr ? flag_clr_data : '0;
    assign ack_mask = ack_hit ? grant : '0;

    always_comb begin
        gie_nx = gie_r;
        if (gie_set || irq_ret) gie_nx = 1'b1;
        if (gie_clr || ack_hit) gie_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= '0;
            mask_r <= '0;
            flag_r <= '0;
            gie_r  <= 1'b0;
        end else begin
            if (mode_wr) mode_r <= mode_wdata;
            if (mask_wr) mask_r <= mask_wdata;
            flag_r <= (flag_r & ~clr_mask & ~ack_mask) | trig;
            gie_r  <= gie_nx;
        end
    end

    assign irq_req = any_elig;
    assign irq_vec = win_idx;
    assign flag_q  = flag_r;
    assign gie_q   = gie_r;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
    parameter int N        = 8,
    parameter int VW       = 3,
    parameter int ANY_FROM = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           irq_req,
    input logic [VW-1:0]  irq_vec,
    input logic           gie_q,
    input logic [N-1:0]   flag_q,
    input logic           irq_ack,
    input logic           irq_ret,
    input logic           gie_set,
    input logic           gie_clr,
    input logic           flag_clr,
    input logic [N-1:0]   flag_clr_data,
    input logic [N-1:0]   mask_r,
    input logic [N-1:0]   lvl_act,
    input logic [N-1:0]   trig,
    input logic [2*N-1:0] mode_r
);
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> gie_q); // R7

    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> mask_r[irq_vec]); // R7

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (((flag_q | lvl_act) & mask_r & ((N'(1) << irq_vec) - N'(1))) == '0)); // R8

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !gie_q); // R9

    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !trig[irq_vec]) |=> !flag_q[$past(irq_vec)]); // R9

    AST_GIE_RAISE: assert property (@(posedge clk) disable iff (rst)
        ((gie_set || irq_ret) && !gie_clr && !(irq_ack && irq_req)) |=> gie_q); // R11

    AST_GIE_DROP: assert property (@(posedge clk) disable iff (rst)
        gie_clr |=> !gie_q); // R11

    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> ((flag_q & $past(flag_clr_data & ~trig)) == '0)); // R10

    for (genvar i = 0; i < N; i++) begin : g_sense
        if (i < ANY_FROM) begin : g_low
            AST_LINE_SENSE: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_q[i]) |-> $past(mode_r[2*i+1])); // R4 R5
        end else begin : g_high
            AST_LINE_SENSE: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_q[i]) |-> ($past(mode_r[2*i +: 2]) != 2'b00)); // R5
        end
    end
endmodule

bind ext_irq_ctrl ext_irq_chk #(.N(N_LINES), .VW(VW), .ANY_FROM(ANY_FROM)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_req       (irq_req),
    .irq_vec       (irq_vec),
    .gie_q         (gie_q),
    .flag_q        (flag_q),
    .irq_ack       (irq_ack),
    .irq_ret       (irq_ret),
    .gie_set       (gie_set),
    .gie_clr       (gie_clr),
    .flag_clr      (flag_clr),
    .flag_clr_data (flag_clr_data),
    .mask_r        (mask_r),
    .lvl_act       (lvl_act),
    .trig          (trig),
    .mode_r        (mode_r)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = 8'hFF;
    logic        mode_wr = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic        mask_wr = 1'b0;
    logic [7:0]  mask_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [7:0]  flag_clr_data = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
    logic        irq_req;
    logic [2:0]  irq_vec;
    logic [7:0]  flag_q;
    logic        gie_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [7:0]  h [$];
    logic [7:0]  m_flag, m_mask;
    logic [15:0] m_mode;
    logic        m_gie;

    always #5 clk = ~clk;

    ext_irq_ctrl uut (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .flag_clr(flag_clr), .flag_clr_data(flag_clr_data),
        .gie_set(gie_set), .gie_clr(gie_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec),
        .flag_q(flag_q), .gie_q(gie_q)
    );

    function automatic logic [7:0] f_trig(logic [7:0] sy, logic [7:0] pv, logic [15:0] md);
        logic [7:0] t = '0;
        for (int i = 0; i < 8; i++) begin
            case (md[2*i +: 2])
                2'b11: t[i] = sy[i] & ~pv[i];
                2'b10: t[i] = ~sy[i] & pv[i];
                2'b01: t[i] = (i >= 4) ? (sy[i] ^ pv[i]) : 1'b0;
                default: t[i] = 1'b0;
            endcase
        end
        return t;
    endfunction

    function automatic logic [7:0] f_lvl(logic [7:0] sy, logic [15:0] md);
        logic [7:0] l = '0;
        for (int i = 0; i < 8; i++) l[i] = (md[2*i +: 2] == 2'b00) && !sy[i];
        return l;
    endfunction

    function automatic int f_low(logic [7:0] e);
        for (int i = 0; i < 8; i++) if (e[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] m_elig();
        logic [7:0] sy = h[h.size()-2];
        return (m_flag | f_lvl(sy, m_mode)) & m_mask & {8{m_gie}};
    endfunction

    task automatic model_edge();
        logic [7:0] sy, pv, tr, el;
        int v;
        if (rst) begin
            h = '{8'hFF, 8'hFF, 8'hFF};
            m_flag = '0; m_mask = '0; m_mode = '0; m_gie = 1'b0;
            return;
        end
        sy = h[h.size()-2];
        pv = h[h.size()-3];
        tr = f_trig(sy, pv, m_mode);
        el = m_elig();
        v  = f_low(el);
        if (flag_clr) m_flag = m_flag & ~flag_clr_data;
        if (irq_ack && v >= 0) m_flag[v] = 1'b0;
        m_flag = m_flag | tr;
        if (gie_set || irq_ret) m_gie = 1'b1;
        if (gie_clr || (irq_ack && v >= 0)) m_gie = 1'b0;
        if (mode_wr) m_mode = mode_wdata;
        if (mask_wr) m_mask = mask_wdata;
        h.push_back(pin_in);
        void'(h.pop_front());
    endtask

    task automatic compare();
        logic [7:0] el = m_elig();
        int v = f_low(el);
        checks++;
        if (irq_req !== (v >= 0) || (v >= 0 && irq_vec !== 3'(v))) begin
            fails++;
            $display("FAIL R7/R8 req/vec: actual %0b/%0d expected %0b/%0d", irq_req, irq_vec, v >= 0, v);
        end else if (flag_q !== m_flag) begin
            fails++;
            $display("FAIL R6/R10 flags: actual %02h expected %02h", flag_q, m_flag);
        end else if (gie_q !== m_gie) begin
            fails++;
            $display("FAIL R11 enable: actual %0b expected %0b", gie_q, m_gie);
        end
    endtask

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse_ack();   irq_ack = 1; step(); irq_ack = 0; endtask
    task automatic pulse_ret();   irq_ret = 1; step(); irq_ret = 0; endtask
    task automatic pulse_set();   gie_set = 1; step(); gie_set = 0; endtask
    task automatic clear(logic [7:0] d);
        flag_clr = 1; flag_clr_data = d; step(); flag_clr = 0;
    endtask
    task automatic set_mode(logic [15:0] d);
        mode_wr = 1; mode_wdata = d; step(); mode_wr = 0;
    endtask

    initial begin
        h = '{8'hFF, 8'hFF, 8'hFF};
        m_flag = '0; m_mask = '0; m_mode = '0; m_gie = 1'b0;
        step(3);
        rst = 0;
        step(2);
        chk("R1 flags", flag_q, 8'h00);
        chk("R1 enable", {7'd0, gie_q}, 8'h00);
        chk("R1 request", {7'd0, irq_req}, 8'h00);

        // R2, R6: rise on line 2 while masked off
        set_mode(16'hFFFF);
        pin_in = 8'hFB; step(4);
        pin_in = 8'hFF; step(4);
        chk("R2 rise flag", flag_q, 8'h04);
        chk("R6 flag while masked", {7'd0, irq_req}, 8'h00);

        // R7: mask on, enable off then on
        mask_wr = 1; mask_wdata = 8'hFF; step(); mask_wr = 0;
        step(2);
        chk("R7 no enable", {7'd0, irq_req}, 8'h00);
        pulse_set();
        chk("R7 request", {7'd0, irq_req}, 8'h01);
        chk("R7 vector", {5'd0, irq_vec}, 8'h02);

        // R8: lines 1 and 5 join
        pin_in = 8'hDD; step(4);
        pin_in = 8'hFF; step(4);
        chk("R8 flags", flag_q, 8'h26);
        chk("R8 lowest wins", {5'd0, irq_vec}, 8'h01);

        // R9, R11: acknowledge and return
        pulse_ack();
        chk("R9 served flag", flag_q, 8'h24);
        chk("R9 enable dropped", {7'd0, gie_q}, 8'h00);
        pulse_ack();
        chk("R9 ack without request", flag_q, 8'h24);
        pulse_ret();
        chk("R11 return", {7'd0, gie_q}, 8'h01);
        chk("R8 next vector", {5'd0, irq_vec}, 8'h02);
        pulse_ack();
        chk("R9 second ack", flag_q, 8'h20);

        // R10: write-1 clear, write-0 no effect
        clear(8'h20);
        chk("R10 cleared", flag_q, 8'h00);
        pin_in = 8'hDF; step(4); pin_in = 8'hFF; step(4);
        clear(8'h00);
        chk("R10 zero write", flag_q, 8'h20);
        clear(8'hFF);
        chk("R10 clear all", flag_q, 8'h00);

        // R3: falling on line 3
        set_mode(16'hFFBF);
        pin_in = 8'hF7; step(5);
        chk("R3 fall flag", flag_q, 8'h08);
        clear(8'h08);
        pin_in = 8'hFF; step(5);
        chk("R3 no rise", flag_q, 8'h00);

        // R4: both edges on line 6, disabled on line 0
        set_mode(16'hDFBD);
        pin_in = 8'hBE; step(5);
        chk("R4 fall edge", flag_q, 8'h40);
        clear(8'h40);
        pin_in = 8'hFF; step(5);
        chk("R4 rise edge", flag_q, 8'h40);
        clear(8'hFF);

        // R5: level on line 7
        set_mode(16'h1FBD);
        pulse_set();
        pin_in = 8'h7F; step(4);
        chk("R5 level request", {7'd0, irq_req}, 8'h01);
        chk("R5 level vector", {5'd0, irq_vec}, 8'h07);
        chk("R5 no latch", flag_q, 8'h00);
        pulse_ack();
        chk("R5 ack level", {gie_q, flag_q[6:0]}, 8'h00);
        pulse_set();
        chk("R5 still low", {7'd0, irq_req}, 8'h01);
        pin_in = 8'hFF; step(4);
        chk("R5 released", {7'd0, irq_req}, 8'h00);

        // R11: clear beats set
        gie_set = 1; gie_clr = 1; step(); gie_set = 0; gie_clr = 0;
        chk("R11 clear wins", {7'd0, gie_q}, 8'h00);
        irq_ret = 1; gie_clr = 1; step(); irq_ret = 0; gie_clr = 0;
        chk("R11 clear beats return", {7'd0, gie_q}, 8'h00);

        // random phase checked against the model each clock
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 6 == 0) pin_in = pin_in ^ (8'd1 << ($urandom % 8));
            mode_wr = ($urandom % 60 == 0); mode_wdata = 16'($urandom);
            mask_wr = ($urandom % 40 == 0); mask_wdata = 8'($urandom);
            flag_clr = ($urandom % 10 == 0); flag_clr_data = 8'($urandom);
            gie_set = ($urandom % 12 == 0);
            gie_clr = ($urandom % 40 == 0);
            irq_ack = ($urandom % 4 == 0);
            irq_ret = ($urandom % 10 == 0);
            step();
        end
        mode_wr = 0; mask_wr = 0; flag_clr = 0;
        gie_set = 0; gie_clr = 0; irq_ack = 0; irq_ret = 0;
        step(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule